// File: doc/BRIEF.md
# Atrial tachycardia fallback detector

This block decides when a dual-chamber pacer must stop tracking the atrium and fall back to pacing the ventricle alone, and when it may resume tracking. It times the gap between accepted atrial senses (normal senses and senses that land in the refractory window, with blanked events already removed upstream). It classes every gap as fast or slow against a programmable tick threshold. It keeps a saturating up/down evidence count of those verdicts.

Once the evidence count reaches an entry threshold, the block opens a confirmation window that lasts a set number of ventricular events, sensed or paced. If evidence remains at the window's end, the mode flips to fallback. Whenever the evidence count drains to zero, any open window is dropped and the mode returns to dual-chamber. Atrial paces restart gap timing without producing a verdict. The block only drives the mode flag and one-cycle change strobes. The pacing timers that consume them live elsewhere.

Top module: `atach_fallback_detector`

## Requirements
- R1: While and after reset the mode output is dual-chamber (fallback_mode = 0) and both strobes are 0.
- R2: An atrial sense with no earlier atrial event since reset only starts gap timing and yields no fast/slow verdict.
- R3: A gap is fast when fewer than FAST_TICKS tick_ms pulses were seen between two atrial senses, and slow otherwise. A normal sense and a refractory sense count alike. A tick in the same cycle as an atrial event is not counted.
- R4: Each fast verdict raises the evidence count by one and each slow verdict lowers it by one. The count holds at 0 and at CNT_MAX.
- R5: In dual-chamber mode with no window open, an evidence count of at least ENTRY_COUNT opens a confirmation window. Only ventricular events seen while the window is open advance it.
- R6: On the DUR_BEATS-th ventricular event of an open window, with evidence above zero, fallback_mode becomes 1. It does so at the same clock edge that samples that event, and sw_to_fallback pulses high for exactly that one cycle.
- R7: When the evidence count is zero, any open window is abandoned and the mode is dual-chamber two clock edges after the edge that sampled the draining atrial sense. sw_to_dual pulses for one cycle only if the mode was fallback. A later window counts its beats from zero.
- R8: An atrial pace restarts gap timing and yields no verdict, so the next sense is measured from the pace.
- R9: The gap timer saturates rather than wrapping, so arbitrarily long gaps are always slow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| atr_sense | input | 1 | Normal atrial sense strobe (post blanking) |
| atr_refr_sense | input | 1 | Atrial sense inside the refractory window (post blanking) |
| atr_pace | input | 1 | Atrial pace strobe |
| vent_evt | input | 1 | Ventricular sense or pace strobe |
| fallback_mode | output | 1 | 1 = ventricle-only fallback, 0 = dual-chamber |
| sw_to_fallback | output | 1 | One-cycle strobe on entry to fallback |
| sw_to_dual | output | 1 | One-cycle strobe on return to dual-chamber |

## Verification
The bench builds the block with FAST_TICKS = 20, ENTRY_COUNT = 4, DUR_BEATS = 3 and CNT_MAX = 6, with ticks issued under bench control. These small values put the full entry, confirmation, saturation and drain sequences within a few hundred ticks. They also make the timer just 5 bits wide, so a 37-tick gap would alias to a fast gap if the timer wrapped. With CNT_MAX below the number of fast gaps applied, the point at which the mode returns shows whether the counter saturated.

// File: rtl/atach_pkg.sv
package atach_pkg;

    typedef enum logic [1:0] {
        PH_WATCH   = 2'd0,
        PH_CONFIRM = 2'd1,
        PH_HOLD    = 2'd2
    } ms_phase_e;

    typedef struct packed {
        logic vld;
        logic fast;
    } ms_verdict_t;

    function automatic int unsigned ms_next_count(int unsigned cur, logic up, int unsigned top);
        if (up)
            return (cur >= top) ? top : cur + 1;
        else
            return (cur == 0) ? 0 : cur - 1;
    endfunction

endpackage

// File: rtl/atach_interval_classifier.sv
module atach_interval_classifier
    import atach_pkg::*;
#(
    parameter int unsigned FAST_TICKS = 350
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_ms,
    input  logic        sense_evt,
    input  logic        pace_evt,
    output ms_verdict_t verdict
);
    localparam int unsigned TW = $clog2(FAST_TICKS + 1);
    localparam logic [TW-1:0] T_CAP = TW'(FAST_TICKS);

    logic [TW-1:0] tmr_q;
    logic          armed_q;
    ms_verdict_t   verdict_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q     <= '0;
            armed_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            verdict_q.vld  <= sense_evt && armed_q;
            verdict_q.fast <= tmr_q < T_CAP;
            if (sense_evt || pace_evt) begin
                tmr_q   <= '0;
                armed_q <= 1'b1;
            end else if (tick_ms && tmr_q != T_CAP) begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    assign verdict = verdict_q;

    AST_VERDICT_NEEDS_SENSE: assert property (@(posedge clk) disable iff (rst)
        verdict_q.vld |-> $past(sense_evt)); // R2
    AST_TIMER_CAPPED: assert property (@(posedge clk) disable iff (rst)
        tmr_q <= T_CAP); // R9
    AST_TIMER_MONOTONE: assert property (@(posedge clk) disable iff (rst)
        !(sense_evt || pace_evt) |=> tmr_q >= $past(tmr_q)); // R9

endmodule

// File: rtl/atach_evidence_counter.sv
module atach_evidence_counter
    import atach_pkg::*;
#(
    parameter int unsigned CNT_MAX = 15
) (
    input  logic                               clk,
    input  logic                               rst,
    input  ms_verdict_t                        verdict,
    output logic [$clog2(CNT_MAX + 1)-1:0]     count
);
    localparam int unsigned CW = $clog2(CNT_MAX + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (verdict.vld)
            cnt_q <= CW'(ms_next_count(int'(cnt_q), verdict.fast, CNT_MAX));
    end

    assign count = cnt_q;

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(CNT_MAX)); // R4
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !verdict.vld |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/atach_mode_ctrl.sv
module atach_mode_ctrl
    import atach_pkg::*;
#(
    parameter int unsigned ENTRY_COUNT = 8,
    parameter int unsigned DUR_BEATS   = 8,
    parameter int unsigned CNT_MAX     = 15
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [$clog2(CNT_MAX + 1)-1:0] count,
    input  logic                           vent_evt,
    output logic                           fallback_mode,
    output logic                           sw_to_fallback,
    output logic                           sw_to_dual
);
    localparam int unsigned CW = $clog2(CNT_MAX + 1);
    localparam int unsigned BW = $clog2(DUR_BEATS + 1);
    localparam logic [BW-1:0] LAST_BEAT = BW'(DUR_BEATS - 1);

    ms_phase_e     phase_q, phase_d;
    logic [BW-1:0] beats_q, beats_d;
    logic          to_fb_q, to_fb_d, to_dual_q, to_dual_d;

    always_comb begin
        phase_d   = phase_q;
        beats_d   = beats_q;
        to_fb_d   = 1'b0;
        to_dual_d = 1'b0;
        if (count == '0) begin
            phase_d   = PH_WATCH;
            beats_d   = '0;
            to_dual_d = (phase_q == PH_HOLD);
        end else begin
            case (phase_q)
                PH_WATCH: begin
                    if (count >= CW'(ENTRY_COUNT)) begin
                        phase_d = PH_CONFIRM;
                        beats_d = '0;
                    end
                end
                PH_CONFIRM: begin
                    if (vent_evt) begin
                        if (beats_q == LAST_BEAT) begin
                            phase_d = PH_HOLD;
                            beats_d = '0;
                            to_fb_d = 1'b1;
                        end else begin
                            beats_d = beats_q + 1'b1;
                        end
                    end
                end
                PH_HOLD: ;
                default: phase_d = PH_WATCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_WATCH;
            beats_q   <= '0;
            to_fb_q   <= 1'b0;
            to_dual_q <= 1'b0;
        end else begin
            phase_q   <= phase_d;
            beats_q   <= beats_d;
            to_fb_q   <= to_fb_d;
            to_dual_q <= to_dual_d;
        end
    end

    assign fallback_mode  = (phase_q == PH_HOLD);
    assign sw_to_fallback = to_fb_q;
    assign sw_to_dual     = to_dual_q;

    AST_BEATS_BOUND: assert property (@(posedge clk) disable iff (rst)
        beats_q < BW'(DUR_BEATS)); // R5
    AST_FALLBACK_ON_VENT: assert property (@(posedge clk) disable iff (rst)
        $rose(fallback_mode) |-> $past(vent_evt)); // R5
    AST_FB_STROBE_EDGE: assert property (@(posedge clk) disable iff (rst)
        sw_to_fallback |-> fallback_mode && !$past(fallback_mode)); // R6
    AST_DUAL_STROBE_EDGE: assert property (@(posedge clk) disable iff (rst)
        sw_to_dual |-> !fallback_mode && $past(fallback_mode)); // R7
    AST_ZERO_RETURNS_DUAL: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |=> !fallback_mode); // R7

endmodule

// File: rtl/atach_fallback_detector.sv
module atach_fallback_detector
    import atach_pkg::*;
#(
    parameter int unsigned FAST_TICKS  = 350,
    parameter int unsigned ENTRY_COUNT = 8,
    parameter int unsigned DUR_BEATS   = 8,
    parameter int unsigned CNT_MAX     = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_ms,
    input  logic atr_sense,
    input  logic atr_refr_sense,
    input  logic atr_pace,
    input  logic vent_evt,
    output logic fallback_mode,
    output logic sw_to_fallback,
    output logic sw_to_dual
);
    localparam int unsigned CW = $clog2(CNT_MAX + 1);

    ms_verdict_t   verdict;
    logic [CW-1:0] evidence;
    logic          any_sense;

    assign any_sense = atr_sense || atr_refr_sense;

    atach_interval_classifier #(.FAST_TICKS(FAST_TICKS)) u_cls (
        .clk       (clk),
        .rst       (rst),
        .tick_ms   (tick_ms),
        .sense_evt (any_sense),
        .pace_evt  (atr_pace),
        .verdict   (verdict)
    );

    atach_evidence_counter #(.CNT_MAX(CNT_MAX)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .verdict (verdict),
        .count   (evidence)
    );

    atach_mode_ctrl #(
        .ENTRY_COUNT (ENTRY_COUNT),
        .DUR_BEATS   (DUR_BEATS),
        .CNT_MAX     (CNT_MAX)
    ) u_ctl (
        .clk            (clk),
        .rst            (rst),
        .count          (evidence),
        .vent_evt       (vent_evt),
        .fallback_mode  (fallback_mode),
        .sw_to_fallback (sw_to_fallback),
        .sw_to_dual     (sw_to_dual)
    );

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(sw_to_fallback && sw_to_dual)); // R6

endmodule

// File: tb/atach_fallback_detector_tb.sv
module atach_fallback_detector_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FAST  = 20;
    localparam int ENTRY = 4;
    localparam int DUR   = 3;
    localparam int CMAX  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_ms = 1'b0, atr_sense = 1'b0, atr_refr_sense = 1'b0, atr_pace = 1'b0, vent_evt = 1'b0;
    logic fallback_mode, sw_to_fallback, sw_to_dual;

    int n_cmp = 0, n_bad = 0;
    int n_fb_str = 0, n_dual_str = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    atach_fallback_detector #(
        .FAST_TICKS(FAST), .ENTRY_COUNT(ENTRY), .DUR_BEATS(DUR), .CNT_MAX(CMAX)
    ) u_dut (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .atr_sense(atr_sense),
        .atr_refr_sense(atr_refr_sense), .atr_pace(atr_pace), .vent_evt(vent_evt),
        .fallback_mode(fallback_mode), .sw_to_fallback(sw_to_fallback), .sw_to_dual(sw_to_dual)
    );

    // Behavioural reference: gap in ticks, armed flag, pending verdict,
    // evidence, window state, mode and strobes.
    int  m_gap, m_cnt, m_beats;
    bit  m_armed, m_pv, m_pf, m_open, m_fb, m_sf, m_sd;

    always @(posedge clk) begin
        if (rst) begin
            m_gap = 0; m_cnt = 0; m_beats = 0;
            m_armed = 0; m_pv = 0; m_pf = 0; m_open = 0; m_fb = 0; m_sf = 0; m_sd = 0;
        end else begin
            m_sf = 0; m_sd = 0;
            if (m_cnt == 0) begin
                m_open = 0; m_beats = 0;
                if (m_fb) m_sd = 1;
                m_fb = 0;
            end else if (m_open) begin
                if (vent_evt) begin
                    m_beats++;
                    if (m_beats == DUR) begin
                        m_open = 0; m_beats = 0; m_fb = 1; m_sf = 1;
                    end
                end
            end else if (!m_fb && m_cnt >= ENTRY) begin
                m_open = 1; m_beats = 0;
            end
            if (m_pv) begin
                if (m_pf) m_cnt = (m_cnt < CMAX) ? m_cnt + 1 : CMAX;
                else      m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
            end
            m_pv = 0;
            if (atr_sense || atr_refr_sense) begin
                m_pv = m_armed; m_pf = (m_gap < FAST);
                m_gap = 0; m_armed = 1;
            end else if (atr_pace) begin
                m_gap = 0; m_armed = 1;
            end else if (tick_ms) begin
                m_gap = (m_gap < FAST) ? m_gap + 1 : FAST;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (fallback_mode !== m_fb || sw_to_fallback !== m_sf || sw_to_dual !== m_sd) begin
                n_bad++;
                $display("FAIL model R6/R7 t=%0t act mode=%0b sf=%0b sd=%0b exp mode=%0b sf=%0b sd=%0b",
                         $time, fallback_mode, sw_to_fallback, sw_to_dual, m_fb, m_sf, m_sd);
            end
            if (!rst && sw_to_fallback === 1'b1) n_fb_str++;
            if (!rst && sw_to_dual === 1'b1) n_dual_str++;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic gap(int n);
        repeat (n) begin
            tick_ms = 1'b1; @(negedge clk);
            tick_ms = 1'b0; @(negedge clk);
        end
    endtask

    task automatic sense(bit refr);
        if (refr) atr_refr_sense = 1'b1; else atr_sense = 1'b1;
        @(negedge clk);
        atr_sense = 1'b0; atr_refr_sense = 1'b0;
    endtask

    task automatic pace();
        atr_pace = 1'b1; @(negedge clk); atr_pace = 1'b0;
    endtask

    task automatic beats(int n);
        repeat (n) begin
            vent_evt = 1'b1; @(negedge clk);
            vent_evt = 1'b0; @(negedge clk);
        end
    endtask

    task automatic gaps(int n, int len, bit refr);
        repeat (n) begin gap(len); sense(refr); end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(fallback_mode == 0 && sw_to_fallback == 0 && sw_to_dual == 0, "R1 reset outputs",
              {fallback_mode, sw_to_fallback, sw_to_dual}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(fallback_mode == 0, "R1 after reset", fallback_mode, 0);

        // R2: first sense unclassified -> 4 senses give only 3 fast verdicts
        sense(0);
        gaps(3, 5, 0);
        settle();
        beats(5); settle();
        check(fallback_mode == 0, "R2 first sense no verdict", fallback_mode, 0);
        gaps(1, 5, 0); settle();
        beats(2); settle();
        check(fallback_mode == 0, "R5 window not yet complete", fallback_mode, 0);
        beats(1); settle();
        check(fallback_mode == 1, "R6 fallback after window", fallback_mode, 1);
        check(n_fb_str == 1, "R6 one fallback strobe", n_fb_str, 1);

        // R4: saturation at CMAX then drain
        gaps(4, 5, 0);
        gaps(5, 25, 0); settle();
        check(fallback_mode == 1, "R4 saturated count not yet drained", fallback_mode, 1);
        gaps(1, 25, 0); settle();
        check(fallback_mode == 0, "R7 drained to dual", fallback_mode, 0);
        check(n_dual_str == 1, "R7 dual strobe", n_dual_str, 1);

        // R3: threshold boundary with refractory senses
        gaps(5, FAST, 1); beats(4); settle();
        check(fallback_mode == 0, "R3 gap equal to threshold is slow", fallback_mode, 0);
        gaps(4, FAST - 1, 1); settle(); beats(3); settle();
        check(fallback_mode == 1, "R3 gap below threshold is fast", fallback_mode, 1);
        gaps(4, 25, 0); settle();
        check(fallback_mode == 0 && n_dual_str == 2, "R7 second return", n_dual_str, 2);

        // R7: abandon a window without strobe, next window restarts beats
        gaps(4, 5, 0); settle(); beats(1);
        gaps(4, 25, 0); settle();
        check(n_dual_str == 2, "R7 no strobe when already dual", n_dual_str, 2);
        gaps(4, 5, 0); settle(); beats(2); settle();
        check(fallback_mode == 0, "R7 beats restart after abandon", fallback_mode, 0);
        beats(1); settle();
        check(fallback_mode == 1, "R5 full window after restart", fallback_mode, 1);
        gaps(4, 25, 0); settle();

        // R8: pace restarts measurement, no verdict
        repeat (4) begin gap(30); pace(); gap(5); sense(0); end
        settle(); beats(3); settle();
        check(fallback_mode == 1, "R8 gap measured from pace", fallback_mode, 1);
        gaps(4, 25, 0); settle();
        check(fallback_mode == 0, "R8 return after pace test", fallback_mode, 0);

        // R9: long gaps would alias to fast if the timer wrapped
        gaps(4, 37, 0); settle(); beats(3); settle();
        check(fallback_mode == 0, "R9 long gaps stay slow", fallback_mode, 0);
        check(n_fb_str == 4, "R6 total fallback strobes", n_fb_str, 4);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule